// File: doc/BRIEF.md
# PS/2 Host Port Controller

This block is a memory-mapped host port for a single PS/2 device, such as a keyboard or mouse. Software works through four byte-wide registers on a plain register bus. The bus carries a word index, a write strobe, a read strobe, write data and combinational read data. The block drives the two open-drain lines of the port, clock and data. It exposes each line as a sampled input plus a "pull low" output, and the board resolves the wired-AND outside the block.

A programmable divisor turns the bus clock into a reference tick, normally 8 MHz. The tick times the request-to-send phase of a host transmission. A write to the data register starts one host-to-device byte: the clock is held low, then the data line drops, then the bits are shifted out on the device's falling clock edges, and finally the acknowledge slot is taken.

Device-to-host frames are received into a one-byte holding register, and the odd parity is checked. Two interrupt requests signal a waiting byte and an idle transmitter. Override bits let software pull either line low directly.

Top module: `ps2_host_port`

## Requirements
- R1: After reset, control reads 0x00, divisor reads 0x00, both interrupt outputs are low, neither line is pulled low, and status reads 0x43 when both lines are high.
- R2: Register index 0 is control (6 bits, read back in bits 5:0), index 1 is status (read-only), index 2 is data, and index 3 is the 8-bit divisor. Control bit 2 = enable, bit 3 = transmit interrupt enable, bit 4 = receive interrupt enable, bit 5 = interface type (stored only), bit 1 = pull data low, bit 0 = pull clock low.
- R3: A reference tick occurs once every divisor+1 bus clocks. After a transmission starts, the clock line is pulled low for INHIBIT_TICKS ticks, within one tick period.
- R4: A transmitted frame presents a 0 start bit, eight data bits LSB first, an odd parity bit and a released (1) stop bit. Each bit is changed after a falling edge of the device clock. The 11th falling edge ends the frame (acknowledge slot).
- R5: Status bit 6 (transmitter empty) is 0 and bit 5 (transmit busy) is 1 from the data write until the frame ends. A data write while busy is ignored.
- R6: A device frame (start 0, 8 bits LSB first, parity, stop), sampled on falling clock edges, sets status bit 4 (byte waiting) at the stop bit. A data-register read returns the byte and clears bit 4.
- R7: Status bit 2 is 1 when the last received byte plus its parity bit hold an even number of ones, and 0 otherwise.
- R8: rx_irq equals byte-waiting AND control bit 4. tx_irq equals transmitter-empty AND control bit 3. Both are 0 while control bit 2 is 0.
- R9: Control bit 0 pulls the clock line low and control bit 1 pulls the data line low, whether or not the port is enabled.
- R10: Status bit 1 and bit 0 report the synchronized, filtered clock and data line levels.
- R11: A data write while the port is disabled starts no transmission: the clock line is not pulled low and status bit 6 stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 2 | Register word index |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (clears byte-waiting on a data read) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the addressed register |
| ps2_clk_in | input | 1 | Level of the PS/2 clock line |
| ps2_clk_low | output | 1 | Pull the PS/2 clock line low |
| ps2_dat_in | input | 1 | Level of the PS/2 data line |
| ps2_dat_low | output | 1 | Pull the PS/2 data line low |
| rx_irq | output | 1 | Receive interrupt request |
| tx_irq | output | 1 | Transmit interrupt request |

## Verification
The assertions assume three things:
- The line inputs change slowly compared with the synchronizer and filter latency, so each device clock phase lasts many bus clocks.
- The device drives data only while its clock is high.
- The device never starts a frame while the host is transmitting.

The bench device model keeps each clock phase at twelve bus clocks, which is well above the few cycles of filter delay. It changes data only with the clock released, and it runs receive and transmit frames strictly one after another. Every byte value is swept through the receiver, and a spread of values, including 0x00 and 0xFF, is swept through the transmitter.

// File: rtl/ps2_host_port.sv
module ps2_host_port #(
  parameter int INHIBIT_TICKS = 800,
  parameter int FILT_LEN      = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] addr,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  input  logic       ps2_clk_in,
  output logic       ps2_clk_low,
  input  logic       ps2_dat_in,
  output logic       ps2_dat_low,
  output logic       rx_irq,
  output logic       tx_irq
);
  localparam int INH_W = (INHIBIT_TICKS > 1) ? $clog2(INHIBIT_TICKS) : 1;

  typedef enum logic [1:0] {TX_IDLE, TX_INH, TX_SHIFT} tx_state_t;

  logic [5:0] ctrl;
  logic [7:0] divisor, div_cnt;
  logic       tick;
  logic       en;

  logic [1:0]          clk_s, dat_s;
  logic [FILT_LEN-1:0] clk_h, dat_h;
  logic                f_clk, f_dat, f_clk_d, fall;

  tx_state_t  tx_state;
  logic [7:0] tx_sh;
  logic [3:0] tx_cnt;
  logic [INH_W-1:0] inh_cnt;
  logic       tx_dat_low, tx_idle, start_tx;

  logic [3:0] rx_cnt;
  logic [8:0] rx_sh;
  logic [7:0] rx_data;
  logic       rx_full, rx_perr, rx_done, rd_data;

  assign en       = ctrl[2];
  assign tx_idle  = (tx_state == TX_IDLE);
  assign start_tx = wr_en && addr == 2'd2 && en && tx_idle;
  assign rd_data  = rd_en && addr == 2'd2;
  assign fall     = f_clk_d & ~f_clk;
  assign rx_done  = en && tx_idle && fall && rx_cnt == 4'd10;

  assign ps2_clk_low = ctrl[0] | (tx_state == TX_INH);
  assign ps2_dat_low = ctrl[1] | tx_dat_low;
  assign rx_irq = en & ctrl[4] & rx_full;
  assign tx_irq = en & ctrl[3] & tx_idle;

  always_comb begin
    case (addr)
      2'd0:    rdata = {2'b00, ctrl};
      2'd1:    rdata = {1'b0, tx_idle, ~tx_idle, rx_full, rx_cnt != 4'd0, rx_perr, f_clk, f_dat};
      2'd2:    rdata = rx_data;
      default: rdata = divisor;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl    <= '0;
      divisor <= '0;
    end else if (wr_en) begin
      if (addr == 2'd0) ctrl <= wdata[5:0];
      if (addr == 2'd3) divisor <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_cnt <= '0;
      tick    <= 1'b0;
    end else if (!en) begin
      div_cnt <= '0;
      tick    <= 1'b0;
    end else if (div_cnt >= divisor) begin
      div_cnt <= '0;
      tick    <= 1'b1;
    end else begin
      div_cnt <= div_cnt + 8'd1;
      tick    <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_s   <= 2'b11;
      dat_s   <= 2'b11;
      clk_h   <= '1;
      dat_h   <= '1;
      f_clk   <= 1'b1;
      f_dat   <= 1'b1;
      f_clk_d <= 1'b1;
    end else begin
      clk_s   <= {clk_s[0], ps2_clk_in};
      dat_s   <= {dat_s[0], ps2_dat_in};
      clk_h   <= {clk_h[FILT_LEN-2:0], clk_s[1]};
      dat_h   <= {dat_h[FILT_LEN-2:0], dat_s[1]};
      if (&clk_h) f_clk <= 1'b1;
      else if (~|clk_h) f_clk <= 1'b0;
      if (&dat_h) f_dat <= 1'b1;
      else if (~|dat_h) f_dat <= 1'b0;
      f_clk_d <= f_clk;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_state   <= TX_IDLE;
      tx_sh      <= '0;
      tx_cnt     <= '0;
      inh_cnt    <= '0;
      tx_dat_low <= 1'b0;
    end else if (!en) begin
      tx_state   <= TX_IDLE;
      tx_dat_low <= 1'b0;
    end else begin
      case (tx_state)
        TX_IDLE: if (start_tx) begin
          tx_sh    <= wdata;
          inh_cnt  <= '0;
          tx_state <= TX_INH;
        end
        TX_INH: if (tick) begin
          if (inh_cnt == INH_W'(INHIBIT_TICKS - 1)) begin
            tx_state   <= TX_SHIFT;
            tx_dat_low <= 1'b1;
            tx_cnt     <= '0;
          end else begin
            inh_cnt <= inh_cnt + 1'b1;
          end
        end
        TX_SHIFT: if (fall) begin
          tx_cnt <= tx_cnt + 4'd1;
          if (tx_cnt < 4'd8)       tx_dat_low <= ~tx_sh[tx_cnt[2:0]];
          else if (tx_cnt == 4'd8) tx_dat_low <= ^tx_sh;
          else if (tx_cnt == 4'd9) tx_dat_low <= 1'b0;
          else                     tx_state   <= TX_IDLE;
        end
        default: tx_state <= TX_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_cnt  <= '0;
      rx_sh   <= '0;
      rx_data <= '0;
      rx_full <= 1'b0;
      rx_perr <= 1'b0;
    end else begin
      if (!en || !tx_idle) begin
        rx_cnt <= '0;
      end else if (fall) begin
        if (rx_cnt == 4'd0) begin
          if (!f_dat) rx_cnt <= 4'd1;
        end else if (rx_cnt < 4'd10) begin
          rx_sh  <= {f_dat, rx_sh[8:1]};
          rx_cnt <= rx_cnt + 4'd1;
        end else begin
          rx_data <= rx_sh[7:0];
          rx_perr <= ~^rx_sh;
          rx_cnt  <= '0;
        end
      end
      if (rx_done)      rx_full <= 1'b1;
      else if (rd_data) rx_full <= 1'b0;
    end
  end

  p_irq_off_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !rx_irq && !tx_irq);
  p_rd_clears_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data && !rx_done |=> !rx_full);
  p_inhibit_holds_clk_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_state == TX_INH |-> ps2_clk_low && !tx_dat_low);
  p_busy_write_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == 2'd2 && !tx_idle |=> $stable(tx_sh));
  p_force_lines_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl[0] |-> ps2_clk_low) and (ctrl[1] |-> ps2_dat_low));
  p_no_rx_during_tx_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_idle |=> $stable(rx_full) || !rx_full);
endmodule

// File: tb/test_ps2_host_port.sv
module test_ps2_host_port;
  localparam int CLK_PERIOD = 10;
  localparam int INH = 10;
  localparam int H = 12;

  logic clk = 0, rst_n = 0;
  logic [1:0] addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic host_clk_low, host_dat_low, rx_irq, tx_irq;
  logic dev_clk_low = 0, dev_dat_low = 0;
  logic ps2_clk, ps2_dat;
  int checks = 0, errors = 0;
  bit done = 0;

  assign ps2_clk = ~(host_clk_low | dev_clk_low);
  assign ps2_dat = ~(host_dat_low | dev_dat_low);

  always #(CLK_PERIOD/2) clk = ~clk;

  ps2_host_port #(.INHIBIT_TICKS(INH), .FILT_LEN(3)) i_ps2_host_port (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .ps2_clk_in(ps2_clk), .ps2_clk_low(host_clk_low),
    .ps2_dat_in(ps2_dat), .ps2_dat_low(host_dat_low), .rx_irq(rx_irq), .tx_irq(tx_irq));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    #1 d = rdata;
    @(negedge clk); rd_en = 0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic dev_send(input logic [7:0] b, input bit bad_par);
    logic [10:0] bits;
    bits = {1'b1, (~^b) ^ bad_par, b, 1'b0};
    for (int i = 0; i < 11; i++) begin
      dev_dat_low = ~bits[i];
      wait_cyc(H);
      dev_clk_low = 1;
      wait_cyc(H);
      dev_clk_low = 0;
    end
    dev_dat_low = 0;
    wait_cyc(H);
  endtask

  task automatic dev_recv(output logic [9:0] bits);
    int guard;
    guard = 0;
    bits = '0;
    while (!(ps2_dat == 0 && ps2_clk == 1) && guard < 5000) begin
      @(negedge clk); guard++;
    end
    wait_cyc(H);
    for (int k = 0; k < 10; k++) begin
      dev_clk_low = 1;
      wait_cyc(H);
      bits[k] = ps2_dat;
      dev_clk_low = 0;
      wait_cyc(H);
    end
    dev_dat_low = 1;
    dev_clk_low = 1;
    wait_cyc(H);
    dev_clk_low = 0;
    wait_cyc(H);
    dev_dat_low = 0;
    wait_cyc(H);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    logic [9:0] fr;
    logic [7:0] v;
    int cnt;
    wait_cyc(3);
    rst_n = 1;
    wait_cyc(8);

    rd(2'd1, d); chk("R1 status", d, 8'h43);
    rd(2'd0, d); chk("R1 ctrl", d, 0);
    rd(2'd3, d); chk("R1 divisor", d, 0);
    chk("R1 irqs", {rx_irq, tx_irq}, 0);
    chk("R1 lines", {host_clk_low, host_dat_low}, 0);

    wr(2'd0, 8'hF8); rd(2'd0, d); chk("R2 ctrl readback", d, 8'h38);
    wr(2'd3, 8'hA5); rd(2'd3, d); chk("R2 divisor readback", d, 8'hA5);
    wr(2'd0, 8'h00); wr(2'd3, 8'h01);

    wr(2'd0, 8'h04);
    for (int i = 0; i < 256; i++) begin
      dev_send(8'(i), 0);
      rd(2'd1, d);
      chk("R6 byte waiting", d[4], 1);
      chk("R7 parity ok", d[2], 0);
      rd(2'd2, d); chk("R6 data", d, i);
      rd(2'd1, d); chk("R6 cleared by read", d[4], 0);
    end
    for (int i = 0; i < 4; i++) begin
      v = 8'(i * 67 + 3);
      dev_send(v, 1);
      rd(2'd1, d); chk("R7 parity error flag", d[2], 1);
      rd(2'd2, d); chk("R7 data", d, v);
    end
    dev_send(8'h5A, 0);
    rd(2'd1, d); chk("R7 parity flag clears", d[2], 0);
    rd(2'd2, d);

    wr(2'd0, 8'h14);
    chk("R8 rx_irq idle", rx_irq, 0);
    dev_send(8'h33, 0);
    chk("R8 rx_irq set", rx_irq, 1);
    wr(2'd0, 8'h10); chk("R8 rx_irq gated by disable", rx_irq, 0);
    wr(2'd0, 8'h04); chk("R8 rx_irq without enable bit", rx_irq, 0);
    rd(2'd2, d); chk("R8 data", d, 8'h33);
    wr(2'd0, 8'h0C); chk("R8 tx_irq set", tx_irq, 1);
    wr(2'd0, 8'h08); chk("R8 tx_irq gated", tx_irq, 0);

    wr(2'd0, 8'h04); wr(2'd3, 8'h00);
    for (int i = 0; i < 34; i++) begin
      v = (i == 32) ? 8'h00 : (i == 33) ? 8'hFF : 8'(i * 37 + 5);
      wr(2'd2, v);
      dev_recv(fr);
      chk("R4 tx data", fr[7:0], v);
      chk("R4 tx parity odd", fr[8], ~^v);
      chk("R4 tx stop", fr[9], 1);
      rd(2'd1, d); chk("R5 empty after frame", d[6:5], 2'b10);
    end

    wr(2'd3, 8'h03);
    wr(2'd2, 8'hC3);
    cnt = 0;
    while (host_clk_low && cnt < 1000) begin @(negedge clk); cnt++; end
    checks++;
    if (cnt < INH * 4 - 4 || cnt > INH * 4 + 4) begin
      errors++;
      $display("FAIL R3: actual %0d cycles expected %0d", cnt, INH * 4);
    end
    dev_recv(fr);
    chk("R3 frame after inhibit", fr[7:0], 8'hC3);

    wr(2'd3, 8'h01);
    wr(2'd2, 8'h96);
    rd(2'd1, d); chk("R5 busy status", d[6:5], 2'b01);
    wr(2'd2, 8'h11);
    dev_recv(fr);
    chk("R5 write while busy ignored", fr[7:0], 8'h96);
    wait_cyc(4 * INH);
    chk("R5 no second frame", host_clk_low, 0);

    wr(2'd0, 8'h01); wait_cyc(10);
    chk("R9 clock forced", host_clk_low, 1);
    rd(2'd1, d); chk("R10 clock level", d[1:0], 2'b01);
    wr(2'd0, 8'h02); wait_cyc(10);
    chk("R9 data forced", host_dat_low, 1);
    rd(2'd1, d); chk("R10 data level", d[1:0], 2'b10);
    wr(2'd0, 8'h00); wait_cyc(10);
    rd(2'd1, d); chk("R10 levels released", d[1:0], 2'b11);

    wr(2'd2, 8'h42);
    cnt = 0;
    for (int i = 0; i < 60; i++) begin @(negedge clk); if (host_clk_low) cnt++; end
    chk("R11 no clock pull when disabled", cnt, 0);
    rd(2'd1, d); chk("R11 still empty", d[6], 1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule